// File: doc/BRIEF.md
# Serial Port FIFO Pair with DMA Pacing Outputs

This block holds the two byte queues of a serial port: a transmit queue that the host fills and the serializer drains, and a receive queue that the deserializer fills and the host drains. Each queue is 32 bytes deep by default. Two active-low request outputs tell an external DMA controller when to move data. One request serves the receive side and one serves the transmit side.

A mode input selects how the request outputs behave. This input is bit 3 of the FIFO control register, and the register decode itself sits outside the block. With the mode input at 0, each request output follows the empty or non-empty state of its queue, so the controller moves one byte at a time. With the mode input at 1, each request output has hysteresis, so the controller can move a whole block per request:

- The receive request is raised at a programmable fill level or when a timeout arrives. It is then held until the queue has been emptied.
- The transmit request is released when the queue is full. It is then held until the fill drops below a programmable level.

Write strobes to a full queue and read strobes from an empty queue are dropped. Each dropped strobe is recorded in a sticky flag, and a clear strobe empties both queues and clears the flags.

Top module: `sio_fifo_pacer`

## Requirements
- R1: While the mode input is 0, `rx_dreq_n` is 0 when the receive queue holds one byte or more, and 1 when it is empty.
- R2: While the mode input is 0, `tx_dreq_n` is 1 when the transmit queue holds one byte or more, and 0 when it is empty.
- R3: While the mode input is 1, `rx_dreq_n` falls to 0 on the clock edge where the receive fill reaches the receive trigger level or goes above it. It also falls on an edge that samples `rx_tmo` high while the receive queue is not empty.
- R4: While the mode input is 1, once `rx_dreq_n` is 0 it stays 0 until the receive queue becomes empty. On that edge it returns to 1.
- R5: While the mode input is 1, `tx_dreq_n` rises to 1 on the edge where the transmit queue becomes full. It stays 1 while the fill is at or above the transmit trigger level. It falls to 0 on the edge where the fill drops below that level.
- R6: Each trigger-select field maps to a trigger level as follows: 0 selects 8 bytes, 1 selects 16, 2 selects 24 and 3 selects 28. `rx_trig_sel` sets the receive level and `tx_trig_sel` sets the transmit level, independently of each other.
- R7: An `rx_tmo` pulse that arrives while the receive queue is empty has no effect, and `rx_dreq_n` stays 1.
- R8: Each queue holds up to 32 bytes in first-in first-out order. The oldest byte is always visible on `ser_data` or `host_rdata`. `tx_level` and `rx_level` give the current fill.
- R9: A write to a full queue or a read from an empty queue is dropped and sets that queue's overflow or underflow flag. The flag stays set until `fifo_clr`, which also empties both queues.
- R10: After reset, and on the edge where the mode input changes value, each request output takes the value that the mode-0 rule gives for the fill after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_mode | input | 1 | Mode select (FIFO control bit 3): 1 gives block pacing |
| rx_trig_sel | input | 2 | Receive trigger level select |
| tx_trig_sel | input | 2 | Transmit trigger level select |
| fifo_clr | input | 1 | Empties both queues and clears the sticky flags |
| host_wr | input | 1 | Host write strobe into the transmit queue |
| host_wdata | input | 8 | Host write byte |
| ser_pop | input | 1 | Serializer takes the oldest transmit byte |
| ser_data | output | 8 | Oldest transmit byte |
| des_push | input | 1 | Deserializer write strobe into the receive queue |
| des_data | input | 8 | Received byte |
| host_rd | input | 1 | Host takes the oldest receive byte |
| host_rdata | output | 8 | Oldest receive byte |
| rx_tmo | input | 1 | Receive timeout pulse, one cycle |
| rx_dreq_n | output | 1 | Receive DMA request, active low |
| tx_dreq_n | output | 1 | Transmit DMA request, active low |
| rx_level | output | 6 | Receive fill count |
| tx_level | output | 6 | Transmit fill count |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| tx_unf | output | 1 | Sticky transmit underflow flag |
| rx_unf | output | 1 | Sticky receive underflow flag |

## Verification
Every result here belongs to the rising edge that samples the strobe. That edge updates the fill counts, the sticky flags, the oldest-byte outputs and both request outputs, because each request is a register computed from the fill that follows the edge. The bench therefore changes its inputs just after a falling edge and reads the outputs at the next falling edge, half a period after the edge that produced them. A change of the mode input takes effect on the first rising edge that samples the new value, so the mode-switch vectors are checked one edge later by the same rule.

// File: rtl/sio_pacer_pkg.sv
package sio_pacer_pkg;

  typedef enum logic [1:0] {
    TRIG_QUARTER   = 2'd0,
    TRIG_HALF      = 2'd1,
    TRIG_3QUARTER  = 2'd2,
    TRIG_NEAR_FULL = 2'd3
  } trig_sel_e;

  // Trigger level in bytes for a queue of the given depth.
  function automatic int unsigned trig_bytes(input logic [1:0] sel, input int unsigned depth);
    case (trig_sel_e'(sel))
      TRIG_QUARTER:  return depth / 4;
      TRIG_HALF:     return depth / 2;
      TRIG_3QUARTER: return (3 * depth) / 4;
      default:       return depth - depth / 8;
    endcase
  endfunction

  // Wrapping pointer advance.
  function automatic int unsigned ptr_step(input int unsigned ptr, input int unsigned depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    level,
  output logic [CW-1:0]    level_nxt,
  output logic             ovf,
  output logic             unf
);
  import sio_pacer_pkg::*;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             full, empty, push_ok, pop_ok;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_comb begin
    level_nxt = level;
    if (clr)                    level_nxt = '0;
    else if (push_ok && !pop_ok) level_nxt = level + 1'b1;
    else if (!push_ok && pop_ok) level_nxt = level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ptr_step(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(ptr_step(int'(rd_ptr), DEPTH));
      level <= level_nxt;
      if (push && full) ovf <= 1'b1;
      if (pop && empty) unf <= 1'b1;
    end
  end

endmodule

// File: rtl/sio_dreq_ctrl.sv
module sio_dreq_ctrl #(
  parameter int DEPTH = 32,
  parameter bit IS_RX = 1'b1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_mode,
  input  logic          mode_flip,
  input  logic [CW-1:0] level,
  input  logic [CW-1:0] level_nxt,
  input  logic [CW-1:0] trig,
  input  logic          tmo,
  output logic          dreq_n
);
  localparam logic RST_VAL = IS_RX;  // value of the single-transfer rule for an empty queue

  logic single_n;   // single-transfer rule
  logic block_n;    // block rule with hysteresis
  logic dreq_n_nxt;

  generate
    if (IS_RX) begin : g_rx
      logic tmo_live;
      assign tmo_live = tmo && (level != '0);
      always_comb begin
        single_n = (level_nxt == '0);
        if (level_nxt == '0)                        block_n = 1'b1;
        else if ((level_nxt >= trig) || tmo_live)   block_n = 1'b0;
        else                                        block_n = dreq_n;
      end
    end else begin : g_tx
      always_comb begin
        single_n = (level_nxt != '0);
        if (level_nxt == CW'(DEPTH))   block_n = 1'b1;
        else if (level_nxt < trig)     block_n = 1'b0;
        else                           block_n = dreq_n;
      end
    end
  endgenerate

  assign dreq_n_nxt = (dma_mode && !mode_flip) ? block_n : single_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreq_n <= RST_VAL;
    else        dreq_n <= dreq_n_nxt;
  end

endmodule

// File: rtl/sio_fifo_pacer.sv
module sio_fifo_pacer #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dma_mode,
  input  logic [1:0]       rx_trig_sel,
  input  logic [1:0]       tx_trig_sel,
  input  logic             fifo_clr,
  input  logic             host_wr,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             ser_pop,
  output logic [WIDTH-1:0] ser_data,
  input  logic             des_push,
  input  logic [WIDTH-1:0] des_data,
  input  logic             host_rd,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             rx_tmo,
  output logic             rx_dreq_n,
  output logic             tx_dreq_n,
  output logic [CW-1:0]    rx_level,
  output logic [CW-1:0]    tx_level,
  output logic             tx_ovf,
  output logic             rx_ovf,
  output logic             tx_unf,
  output logic             rx_unf
);
  import sio_pacer_pkg::*;

  // Named internal events, also watched by the checker.
  logic          dma_q;
  logic          mode_flip;
  logic [CW-1:0] rx_trig, tx_trig;
  logic [CW-1:0] rx_level_nxt, tx_level_nxt;

  assign mode_flip = dma_mode ^ dma_q;
  assign rx_trig   = CW'(trig_bytes(rx_trig_sel, DEPTH));
  assign tx_trig   = CW'(trig_bytes(tx_trig_sel, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dma_q <= 1'b0;
    else        dma_q <= dma_mode;
  end

  sio_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(host_wr), .push_data(host_wdata), .pop(ser_pop),
    .head(ser_data), .level(tx_level), .level_nxt(tx_level_nxt),
    .ovf(tx_ovf), .unf(tx_unf)
  );

  sio_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr),
    .push(des_push), .push_data(des_data), .pop(host_rd),
    .head(host_rdata), .level(rx_level), .level_nxt(rx_level_nxt),
    .ovf(rx_ovf), .unf(rx_unf)
  );

  sio_dreq_ctrl #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_req (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .mode_flip(mode_flip),
    .level(rx_level), .level_nxt(rx_level_nxt), .trig(rx_trig),
    .tmo(rx_tmo), .dreq_n(rx_dreq_n)
  );

  sio_dreq_ctrl #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_req (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .mode_flip(mode_flip),
    .level(tx_level), .level_nxt(tx_level_nxt), .trig(tx_trig),
    .tmo(1'b0), .dreq_n(tx_dreq_n)
  );

endmodule

// File: rtl/sio_fifo_pacer_chk.sv
module sio_fifo_pacer_chk #(
  parameter int DEPTH = 32,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dma_mode,
  input logic          mode_flip,
  input logic          fifo_clr,
  input logic          des_push,
  input logic          rx_tmo,
  input logic [CW-1:0] rx_level,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level_nxt,
  input logic [CW-1:0] tx_level_nxt,
  input logic [CW-1:0] rx_trig,
  input logic [CW-1:0] tx_trig,
  input logic          rx_dreq_n,
  input logic          tx_dreq_n,
  input logic          tx_ovf,
  input logic          rx_unf
);
  // Which rule was applied at the last edge.
  logic dma_d, flip_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_d  <= 1'b0;
      flip_d <= 1'b0;
    end else begin
      dma_d  <= dma_mode;
      flip_d <= mode_flip;
    end
  end

  AST_RX_SINGLE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_d || flip_d) |-> (rx_dreq_n == (rx_level == '0))); // R1
  AST_TX_SINGLE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_d || flip_d) |-> (tx_dreq_n == (tx_level != '0))); // R2
  AST_RX_TRIG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && !mode_flip && rx_level_nxt >= rx_trig && rx_level_nxt != '0) |=> !rx_dreq_n); // R3
  AST_RX_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && !mode_flip && !rx_dreq_n && rx_level_nxt != '0) |=> !rx_dreq_n); // R4
  AST_RX_EMPTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level_nxt == '0) |=> rx_dreq_n); // R4
  AST_TX_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && !mode_flip && tx_level_nxt == CW'(DEPTH)) |=> tx_dreq_n); // R5
  AST_TX_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && !mode_flip && tx_dreq_n && tx_level_nxt >= tx_trig) |=> tx_dreq_n); // R5
  AST_TMO_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0 && rx_tmo && !des_push) |=> rx_dreq_n); // R7
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= CW'(DEPTH)) && (tx_level <= CW'(DEPTH))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf && !fifo_clr) |=> tx_ovf); // R9
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_unf && !fifo_clr) |=> rx_unf); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (rx_level == '0 && tx_level == '0 && !tx_ovf && !rx_unf)); // R9

endmodule

bind sio_fifo_pacer sio_fifo_pacer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .mode_flip(mode_flip),
  .fifo_clr(fifo_clr), .des_push(des_push), .rx_tmo(rx_tmo),
  .rx_level(rx_level), .tx_level(tx_level),
  .rx_level_nxt(rx_level_nxt), .tx_level_nxt(tx_level_nxt),
  .rx_trig(rx_trig), .tx_trig(tx_trig),
  .rx_dreq_n(rx_dreq_n), .tx_dreq_n(tx_dreq_n),
  .tx_ovf(tx_ovf), .rx_unf(rx_unf)
);

// File: tb/sio_fifo_pacer_bench.sv
`timescale 1ns/1ps
module sio_fifo_pacer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dma_mode = 1'b0;
  logic [1:0] rx_trig_sel = 2'd0, tx_trig_sel = 2'd0;
  logic       fifo_clr = 1'b0, host_wr = 1'b0, ser_pop = 1'b0;
  logic       des_push = 1'b0, host_rd = 1'b0, rx_tmo = 1'b0;
  logic [7:0] host_wdata = 8'h00, des_data = 8'h00;
  logic [7:0] ser_data, host_rdata;
  logic       rx_dreq_n, tx_dreq_n, tx_ovf, rx_ovf, tx_unf, rx_unf;
  logic [5:0] rx_level, tx_level;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sio_fifo_pacer u_sio_fifo_pacer (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
    .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel), .fifo_clr(fifo_clr),
    .host_wr(host_wr), .host_wdata(host_wdata), .ser_pop(ser_pop), .ser_data(ser_data),
    .des_push(des_push), .des_data(des_data), .host_rd(host_rd), .host_rdata(host_rdata),
    .rx_tmo(rx_tmo), .rx_dreq_n(rx_dreq_n), .tx_dreq_n(tx_dreq_n),
    .rx_level(rx_level), .tx_level(tx_level),
    .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .tx_unf(tx_unf), .rx_unf(rx_unf)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One stimulus step: inputs held through reps rising edges.
  typedef struct packed {
    logic       dma;
    logic [1:0] rsel;
    logic [1:0] tsel;
    logic       dpush;
    logic       hrd;
    logic       hwr;
    logic       spop;
    logic       tmo;
    logic [5:0] reps;
    logic [5:0] e_rlvl;
    logic [5:0] e_tlvl;
    logic       e_rn;
    logic       e_tn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1,  6'd1,  6'd0,  1'b0, 1'b0, 4'd1},  // R1 one byte in rx
    '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd3,  6'd1,  6'd3,  1'b0, 1'b1, 4'd2},  // R2 tx non-empty
    '{1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd1,  6'd0,  6'd3,  1'b1, 1'b1, 4'd1},  // R1 rx drained
    '{1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd3,  6'd0,  6'd0,  1'b1, 1'b0, 4'd2},  // R2 tx drained
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1,  6'd0,  6'd0,  1'b1, 1'b0, 4'd10}, // R10 enter block mode
    '{1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd7,  6'd7,  6'd0,  1'b1, 1'b0, 4'd3},  // R3 below trigger
    '{1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1,  6'd8,  6'd0,  1'b0, 1'b0, 4'd3},  // R3 trigger 8 reached
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd5,  6'd3,  6'd0,  1'b0, 1'b0, 4'd4},  // R4 held low
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd3,  6'd0,  6'd0,  1'b1, 1'b0, 4'd4},  // R4 released on empty
    '{1'b1, 2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd2,  6'd2,  6'd0,  1'b1, 1'b0, 4'd3},  // R3 two bytes, no request
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'd1,  6'd2,  6'd0,  1'b0, 1'b0, 4'd3},  // R3 timeout request
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd2,  6'd0,  6'd0,  1'b1, 1'b0, 4'd4},  // R4 drained after timeout
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd20, 6'd0,  6'd20, 1'b1, 1'b0, 4'd5},  // R5 filling, stays 0
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd12, 6'd0,  6'd32, 1'b1, 1'b1, 4'd5},  // R5 full sets 1
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd24, 6'd0,  6'd8,  1'b1, 1'b1, 4'd5},  // R5 at trigger, held
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd1,  6'd0,  6'd7,  1'b1, 1'b0, 4'd5},  // R5 below trigger
    '{1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 6'd25, 6'd0,  6'd32, 1'b1, 1'b1, 4'd6},  // R6 tx level 28, full
    '{1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd4,  6'd0,  6'd28, 1'b1, 1'b1, 4'd6},  // R6 at 28 held
    '{1'b1, 2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd1,  6'd0,  6'd27, 1'b1, 1'b0, 4'd6},  // R6 below 28
    '{1'b1, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd15, 6'd15, 6'd27, 1'b1, 1'b0, 4'd6},  // R6 rx level 16 not reached
    '{1'b1, 2'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1,  6'd16, 6'd27, 1'b0, 1'b0, 4'd6},  // R6 rx level 16 reached
    '{1'b0, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1,  6'd16, 6'd27, 1'b0, 1'b1, 4'd10}  // R10 leave block mode
  };

  logic [7:0] tx_seq = 8'h40, rx_seq = 8'h80;

  // Called right after a falling edge; returns after the next falling edge.
  task automatic step();
    host_wdata = tx_seq;
    des_data   = rx_seq;
    @(negedge clk);
    if (host_wr)  tx_seq++;
    if (des_push) rx_seq++;
  endtask

  task automatic idle_strobes();
    host_wr = 0; ser_pop = 0; des_push = 0; host_rd = 0; rx_tmo = 0; fifo_clr = 0;
  endtask

  task automatic clear_all();
    fifo_clr = 1'b1;
    step();
    fifo_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "rx_dreq_n after reset", int'(rx_dreq_n), 1);
    chk("R10", "tx_dreq_n after reset", int'(tx_dreq_n), 0);
    chk("R8",  "rx_level after reset", int'(rx_level), 0);
    chk("R9",  "flags after reset", int'({tx_ovf, rx_ovf, tx_unf, rx_unf}), 0);

    for (int i = 0; i < NV; i++) begin
      dma_mode = VECS[i].dma; rx_trig_sel = VECS[i].rsel; tx_trig_sel = VECS[i].tsel;
      des_push = VECS[i].dpush; host_rd = VECS[i].hrd;
      host_wr = VECS[i].hwr; ser_pop = VECS[i].spop; rx_tmo = VECS[i].tmo;
      for (int k = 0; k < int'(VECS[i].reps); k++) step();
      idle_strobes();
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d rx_level", i), int'(rx_level), int'(VECS[i].e_rlvl));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d tx_level", i), int'(tx_level), int'(VECS[i].e_tlvl));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d rx_dreq_n", i), int'(rx_dreq_n), int'(VECS[i].e_rn));
      chk($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d tx_dreq_n", i), int'(tx_dreq_n), int'(VECS[i].e_tn));
    end

    // R10 reset with data queued
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "rx_level after mid reset", int'(rx_level), 0);
    chk("R10", "tx_level after mid reset", int'(tx_level), 0);
    chk("R10", "rx_dreq_n after mid reset", int'(rx_dreq_n), 1);
    chk("R10", "tx_dreq_n after mid reset", int'(tx_dreq_n), 0);

    // R8 order on the receive side
    rx_seq = 8'hA0;
    des_push = 1'b1;
    repeat (3) step();
    idle_strobes();
    for (int k = 0; k < 3; k++) begin
      chk("R8", "host_rdata order", int'(host_rdata), 8'hA0 + k);
      host_rd = 1'b1;
      step();
      host_rd = 1'b0;
    end
    chk("R8", "rx_level drained", int'(rx_level), 0);

    // R9 overflow on transmit, underflow on receive
    tx_seq = 8'h10;
    host_wr = 1'b1;
    repeat (33) step();
    idle_strobes();
    chk("R9", "tx_level at overflow", int'(tx_level), 32);
    chk("R9", "tx_ovf set", int'(tx_ovf), 1);
    chk("R8", "ser_data oldest kept", int'(ser_data), 8'h10);
    ser_pop = 1'b1;
    step();
    idle_strobes();
    chk("R8", "ser_data second byte", int'(ser_data), 8'h11);
    host_rd = 1'b1;
    step();
    idle_strobes();
    chk("R9", "rx_unf set", int'(rx_unf), 1);
    chk("R9", "rx_level after empty read", int'(rx_level), 0);
    step();
    chk("R9", "tx_ovf still set", int'(tx_ovf), 1);
    clear_all();
    chk("R9", "flags cleared", int'({tx_ovf, rx_ovf, tx_unf, rx_unf}), 0);
    chk("R9", "tx_level cleared", int'(tx_level), 0);

    // R7 timeout on an empty receive queue in block mode
    dma_mode = 1'b1;
    step();
    step();
    rx_tmo = 1'b1;
    step();
    idle_strobes();
    chk("R7", "rx_dreq_n after empty timeout", int'(rx_dreq_n), 1);
    step();
    chk("R7", "rx_dreq_n one edge later", int'(rx_dreq_n), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule